// File: doc/BRIEF.md
# Interrupt Dispatch and Exception State Unit

This unit decides, at each instruction boundary, whether a small 16-bit processor core leaves its normal flow for an interrupt handler. It also owns the interrupt-mask flag (I), the test flag (T), a 2-bit saved-flag register and the exception return address. The execute unit raises `disp_rdy` in the cycle in which an instruction completes. In that same cycle it presents any flag or exception command carried by that instruction, together with the address of the next sequential instruction. The unit answers in the same cycle with a redirect strobe and a target address. All of its state then updates on the following rising clock edge.

Two interrupt sources are handled. The maskable request is active-low and level-sensitive. The non-maskable request fires on a falling edge, which is sampled on the falling clock edge. A command that changes I acts on the interrupt decision of its own boundary, so no stale mask value is ever seen. Software interrupts, return-from-interrupt and status reads and writes give software full control over the saved state. A `wake` output tells a halted core that a request is present, whatever the mask.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, I=1, T=0, saved flags = 0, EPC = 0, no NMI is pending, and during the first cycle after reset release `redirect`=1 with `redirect_addr`=0x0000.
- R2: When a falling edge of `nmi_n` is seen in a cycle where `disp_rdy`=1, `redirect`=1 with address 0x0002 in that cycle, whatever the value of I.
- R3: An NMI falling edge seen while `disp_rdy`=0 stays pending. It is taken at the next cycle with `disp_rdy`=1 and is serviced exactly once.
- R4: With `irq_n`=0, `disp_rdy`=1 and an effective I of 0, the unit redirects to 0x0006. With an effective I of 1, it does not redirect.
- R5: When NMI and IRQ are both pending, NMI wins (0x0002). The I=1 it sets keeps the still-low IRQ masked at the next boundary.
- R6: On hardware entry, EPC takes the address the flow would have continued at (`ret_pc`, or the target of a software-interrupt or return command at the same boundary), the saved flags take the effective {I,T}, and I becomes 1.
- R7: Software interrupt (`cmd`=3) with vector field v of 0..2 redirects to (v+1)*2, sets EPC=`ret_pc`, saved flags={I,T} and I=1. With v=3, it changes nothing and does not redirect.
- R8: Return (`cmd`=4) redirects to EPC and restores I from saved-flag bit 1 and T from saved-flag bit 0.
- R9: `status_rd` = {zeros, saved[1:0], I, T}. Status write (`cmd`=5) loads the saved flags from `wr_data[3:2]` and {I,T} from `wr_data[1:0]`.
- R10: Mask changes act at their own boundary: clear (`cmd`=2) or return restoring I=0 lets a low `irq_n` redirect in that cycle, and in that case the saved I is 0. Set (`cmd`=1) blocks it.
- R11: `wake` is 1 whenever `irq_n`=0, even with I=1, and in that case no redirect occurs.
- R12: With `disp_rdy`=0, commands have no effect: no redirect, and flags, saved flags and EPC hold.
- R13: T write (`cmd`=6) sets T to `wr_data[0]`. Command codes: 0 none, 1 set I, 2 clear I, 3 software interrupt, 4 return, 5 status write, 6 T write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_n | input | 1 | Maskable request, active-low level |
| nmi_n | input | 1 | Non-maskable request, falling-edge |
| disp_rdy | input | 1 | Instruction boundary from execute unit |
| cmd | input | 3 | Command of the completing instruction |
| swi_vec | input | 2 | Software-interrupt vector number |
| wr_data | input | 16 | Status-write / T-write operand |
| ret_pc | input | 16 | Address of next sequential instruction |
| redirect | output | 1 | PC redirect strobe this cycle |
| redirect_addr | output | 16 | Redirect target |
| wake | output | 1 | Any interrupt request present |
| flag_i | output | 1 | Interrupt-mask flag |
| flag_t | output | 1 | Test flag |
| epc | output | 16 | Exception return address |
| status_rd | output | 16 | Status read value |

## Verification
On every cycle, the assertions check the following. Non-return redirects leave I set. A set mask never lets an IRQ redirect through on a plain boundary. Idle cycles produce no redirect and hold all state. Reset release presents the reset redirect. Only the bench's scenarios can show the ordering cases: an NMI edge that is held pending and serviced once, NMI winning over a simultaneous IRQ, a clear or return command firing a waiting IRQ in its own cycle with the saved flags it leaves behind, and the exact EPC and saved-flag values after software and hardware entry.

// File: rtl/exc_pkg.sv
// Shared command encoding and vector addresses for the dispatch unit.
package exc_pkg;
    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_SETI = 3'd1,
        CMD_CLRI = 3'd2,
        CMD_SWI  = 3'd3,
        CMD_RET  = 3'd4,
        CMD_SWR  = 3'd5,
        CMD_TWR  = 3'd6
    } exc_cmd_e;

    localparam logic [15:0] VEC_RESET = 16'h0000;
    localparam logic [15:0] VEC_NMI   = 16'h0002;
    localparam logic [15:0] VEC_IRQ   = 16'h0006;
    localparam logic [1:0]  SWI_NOP   = 2'd3;
endpackage

// File: rtl/exc_nmi_sense.sv
// Samples the NMI pin on the falling clock edge and reports a falling edge
// for one full cycle. Keeps an edge pending until the arbiter services it.
// Assumes nmi_n is stable around the falling clock edge.
module exc_nmi_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic taken,
    output logic nmi_req
);
    logic smp_now, smp_prev, pend_q, edge_seen;

    // Falling-edge sampling: current and previous pin samples.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            smp_now  <= 1'b1;
            smp_prev <= 1'b1;
        end else begin
            smp_now  <= nmi_n;
            smp_prev <= smp_now;
        end
    end

    assign edge_seen = smp_prev & ~smp_now;

    // Pending latch: holds an edge until it is serviced.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q | edge_seen) & ~taken;
    end

    assign nmi_req = edge_seen | pend_q;
endmodule

// File: rtl/exc_arbiter.sv
// Combinational boundary decision: applies the completing command to the
// flags, then chooses NMI, IRQ, command redirect or nothing, and forms the
// next exception state. Assumes cmd is meaningful only when go=1.
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              boot,
    input  logic              go,
    input  exc_cmd_e          cmd,
    input  logic [1:0]        swi_vec,
    input  logic [3:0]        wr_nib,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic              irq_n,
    input  logic              nmi_req,
    input  logic              cur_i,
    input  logic              cur_t,
    input  logic [1:0]        cur_esr,
    input  logic [ADDR_W-1:0] cur_epc,
    output logic              nmi_take,
    output logic              nxt_i,
    output logic              nxt_t,
    output logic [1:0]        nxt_esr,
    output logic [ADDR_W-1:0] nxt_epc,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_addr
);
    logic              swi_ok, irq_take, hw;
    logic              i_eff, t_eff;
    logic [1:0]        esr_cmd;
    logic [ADDR_W-1:0] epc_cmd, swi_tgt, flow;

    assign swi_ok  = (cmd == CMD_SWI) && (swi_vec != SWI_NOP);
    assign swi_tgt = ADDR_W'(({1'b0, swi_vec} + 3'd1) << 1);

    // Flag values after the completing command, before any entry.
    always_comb begin
        i_eff = cur_i;
        t_eff = cur_t;
        unique case (cmd)
            CMD_SETI: i_eff = 1'b1;
            CMD_CLRI: i_eff = 1'b0;
            CMD_SWI:  i_eff = swi_ok ? 1'b1 : cur_i;
            CMD_RET:  {i_eff, t_eff} = cur_esr;
            CMD_SWR:  {i_eff, t_eff} = wr_nib[1:0];
            CMD_TWR:  t_eff = wr_nib[0];
            default:  ;
        endcase
    end

    // Saved state the command alone would leave, and where flow continues.
    always_comb begin
        esr_cmd = (cmd == CMD_SWR) ? wr_nib[3:2] : (swi_ok ? {cur_i, cur_t} : cur_esr);
        epc_cmd = swi_ok ? ret_pc : cur_epc;
        flow    = swi_ok ? swi_tgt : ((cmd == CMD_RET) ? cur_epc : ret_pc);
    end

    assign nmi_take = go & nmi_req;
    assign irq_take = go & ~irq_n & ~i_eff & ~nmi_take;
    assign hw       = nmi_take | irq_take;

    // Next state: hardware entry overrides the command's saved state.
    always_comb begin
        nxt_i   = hw ? 1'b1 : i_eff;
        nxt_t   = t_eff;
        nxt_esr = hw ? {i_eff, t_eff} : esr_cmd;
        nxt_epc = hw ? flow : epc_cmd;
    end

    // Redirect target, by priority.
    always_comb begin
        redirect = boot | hw | (go & (swi_ok | (cmd == CMD_RET)));
        if (boot)          redirect_addr = ADDR_W'(VEC_RESET);
        else if (nmi_take) redirect_addr = ADDR_W'(VEC_NMI);
        else if (irq_take) redirect_addr = ADDR_W'(VEC_IRQ);
        else if (swi_ok)   redirect_addr = swi_tgt;
        else               redirect_addr = cur_epc;
    end
endmodule

// File: rtl/exc_state.sv
// Architectural flag and exception registers. Loads the arbiter's next
// values only at a dispatch boundary; reset gives the boot state.
module exc_state #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              nxt_i,
    input  logic              nxt_t,
    input  logic [1:0]        nxt_esr,
    input  logic [ADDR_W-1:0] nxt_epc,
    output logic              boot,
    output logic              cur_i,
    output logic              cur_t,
    output logic [1:0]        cur_esr,
    output logic [ADDR_W-1:0] cur_epc
);
    // Boot marker: one cycle of reset redirect after release.
    always_ff @(posedge clk) begin
        if (!rst_n) boot <= 1'b1;
        else        boot <= 1'b0;
    end

    // Flag and exception registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_i   <= 1'b1;
            cur_t   <= 1'b0;
            cur_esr <= 2'b00;
            cur_epc <= '0;
        end else if (load) begin
            cur_i   <= nxt_i;
            cur_t   <= nxt_t;
            cur_esr <= nxt_esr;
            cur_epc <= nxt_epc;
        end
    end
endmodule

// File: rtl/exc_dispatch.sv
// Top of the interrupt dispatch unit: NMI sensing, boundary arbitration and
// exception state. Redirect is combinational in the boundary cycle; state
// updates on the next rising edge. Assumes DATA_W >= 4.
module exc_dispatch
    import exc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_n,
    input  logic              nmi_n,
    input  logic              disp_rdy,
    input  logic [2:0]        cmd,
    input  logic [1:0]        swi_vec,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] ret_pc,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              wake,
    output logic              flag_i,
    output logic              flag_t,
    output logic [ADDR_W-1:0] epc,
    output logic [DATA_W-1:0] status_rd
);
    localparam int PAD_W = DATA_W - 4;

    logic              boot, go, nmi_req, nmi_take;
    logic              nxt_i, nxt_t;
    logic [1:0]        nxt_esr, cur_esr;
    logic [ADDR_W-1:0] nxt_epc;

    assign go = disp_rdy & ~boot;

    exc_nmi_sense u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_n   (nmi_n),
        .taken   (nmi_take),
        .nmi_req (nmi_req)
    );

    exc_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .boot          (boot),
        .go            (go),
        .cmd           (exc_cmd_e'(cmd)),
        .swi_vec       (swi_vec),
        .wr_nib        (wr_data[3:0]),
        .ret_pc        (ret_pc),
        .irq_n         (irq_n),
        .nmi_req       (nmi_req),
        .cur_i         (flag_i),
        .cur_t         (flag_t),
        .cur_esr       (cur_esr),
        .cur_epc       (epc),
        .nmi_take      (nmi_take),
        .nxt_i         (nxt_i),
        .nxt_t         (nxt_t),
        .nxt_esr       (nxt_esr),
        .nxt_epc       (nxt_epc),
        .redirect      (redirect),
        .redirect_addr (redirect_addr)
    );

    exc_state #(.ADDR_W(ADDR_W)) u_st (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (go),
        .nxt_i   (nxt_i),
        .nxt_t   (nxt_t),
        .nxt_esr (nxt_esr),
        .nxt_epc (nxt_epc),
        .boot    (boot),
        .cur_i   (flag_i),
        .cur_t   (flag_t),
        .cur_esr (cur_esr),
        .cur_epc (epc)
    );

    assign wake      = ~irq_n | nmi_req;
    assign status_rd = {{PAD_W{1'b0}}, cur_esr, flag_i, flag_t};
endmodule

// File: rtl/exc_dispatch_chk.sv
// Property checker for exc_dispatch, attached by bind below.
module exc_dispatch_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_rdy,
    input logic [2:0]        cmd,
    input logic              redirect,
    input logic [ADDR_W-1:0] redirect_addr,
    input logic              flag_i,
    input logic              flag_t,
    input logic [ADDR_W-1:0] epc,
    input logic [DATA_W-1:0] status_rd
);
    // Any redirect other than a return leaves the mask set.
    assert_entry_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && cmd != 3'd4) |=> flag_i);

    // A set mask never lets IRQ through on a plain boundary.
    assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_i && cmd == 3'd0) |-> !(redirect && redirect_addr == ADDR_W'(16'h0006)));

    // Outside boundaries and the boot cycle, nothing redirects.
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_rdy && $past(rst_n)) |-> !redirect);

    // Outside boundaries, all exception state holds.
    assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_rdy && $past(rst_n)) |=> ($stable(flag_i) && $stable(flag_t)
                                        && $stable(epc) && $stable(status_rd)));

    // Reset release presents the boot state and the reset redirect.
    assert_boot_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_i && !flag_t && epc == '0 && redirect
                          && redirect_addr == '0));
endmodule

bind exc_dispatch exc_dispatch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .disp_rdy      (disp_rdy),
    .cmd           (cmd),
    .redirect      (redirect),
    .redirect_addr (redirect_addr),
    .flag_i        (flag_i),
    .flag_t        (flag_t),
    .epc           (epc),
    .status_rd     (status_rd)
);

// File: tb/sim_exc_dispatch.sv
// Directed bench for exc_dispatch: one task per scenario.
module sim_exc_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_n = 1'b1, nmi_n = 1'b1, disp_rdy = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [1:0]  swi_vec = 2'd0;
    logic [15:0] wr_data = 16'd0, ret_pc = 16'd0;
    logic        redirect, wake, flag_i, flag_t;
    logic [15:0] redirect_addr, epc, status_rd;
    int          n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    exc_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
        .disp_rdy(disp_rdy), .cmd(cmd), .swi_vec(swi_vec), .wr_data(wr_data),
        .ret_pc(ret_pc), .redirect(redirect), .redirect_addr(redirect_addr),
        .wake(wake), .flag_i(flag_i), .flag_t(flag_t), .epc(epc),
        .status_rd(status_rd)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic r, input logic [15:0] a);
        chk(redirect === r, {req, " redirect"}, {15'd0, redirect}, {15'd0, r});
        if (r) chk(redirect_addr === a, {req, " addr"}, redirect_addr, a);
    endtask

    task automatic chk_st(input string req, input logic [15:0] st, input logic [15:0] pc);
        chk(status_rd === st, {req, " status"}, status_rd, st);
        chk(epc === pc, {req, " epc"}, epc, pc);
    endtask

    task automatic idle();
        irq_n = 1'b1; nmi_n = 1'b1; disp_rdy = 1'b0;
        cmd = 3'd0; swi_vec = 2'd0; wr_data = 16'd0; ret_pc = 16'd0;
    endtask

    // Inputs applied after a rising edge; combinational outputs settle by here.
    task automatic mid();
        @(negedge clk); #1;
    endtask

    // Rising edge commits state; inputs return to idle.
    task automatic commit();
        @(posedge clk); #1; idle();
    endtask

    task automatic boundary(input logic [2:0] c, input logic [15:0] w);
        disp_rdy = 1'b1; cmd = c; wr_data = w; mid(); commit();
    endtask

    task automatic t_reset();
        idle(); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        mid();
        chk_rd("R1 boot", 1'b1, 16'h0000);
        chk_st("R1 reset", 16'h0002, 16'h0000);
        commit();
        mid();
        chk_rd("R1 after boot", 1'b0, 16'h0);
        commit();
    endtask

    task automatic t_clear_fires_irq();
        irq_n = 1'b0; disp_rdy = 1'b1; cmd = 3'd2; ret_pc = 16'h0100;
        mid();
        chk_rd("R10 clear fires irq", 1'b1, 16'h0006);
        commit();
        chk_st("R10 saved I=0", 16'h0002, 16'h0100);
    endtask

    task automatic t_set_blocks_irq();
        boundary(3'd2, 16'd0);
        chk(flag_i === 1'b0, "R10 clear", {15'd0, flag_i}, 16'd0);
        irq_n = 1'b0; disp_rdy = 1'b1; cmd = 3'd1;
        mid();
        chk_rd("R10 set blocks", 1'b0, 16'h0);
        commit();
        chk_st("R10 set", 16'h0002, 16'h0100);
    endtask

    task automatic t_masked_wake();
        irq_n = 1'b0; disp_rdy = 1'b0;
        mid();
        chk(wake === 1'b1, "R11 wake", {15'd0, wake}, 16'd1);
        chk_rd("R11 no entry", 1'b0, 16'h0);
        commit();
        irq_n = 1'b0; disp_rdy = 1'b1;
        mid();
        chk_rd("R4 masked", 1'b0, 16'h0);
        commit();
        chk_st("R4 masked", 16'h0002, 16'h0100);
    endtask

    task automatic t_irq_entry();
        boundary(3'd2, 16'd0);
        boundary(3'd6, 16'h0001);
        chk_st("R13 T write", 16'h0001, 16'h0100);
        irq_n = 1'b0; disp_rdy = 1'b1; ret_pc = 16'h0200;
        mid();
        chk_rd("R4 irq", 1'b1, 16'h0006);
        commit();
        chk_st("R6 irq entry", 16'h0007, 16'h0200);
    endtask

    task automatic t_ignored();
        disp_rdy = 1'b0; cmd = 3'd3; swi_vec = 2'd1; ret_pc = 16'h7777;
        mid();
        chk_rd("R12 idle swi", 1'b0, 16'h0);
        commit();
        disp_rdy = 1'b0; cmd = 3'd5; wr_data = 16'h0000;
        mid(); commit();
        chk_st("R12 ignored", 16'h0007, 16'h0200);
    endtask

    task automatic t_nmi_over_irq();
        boundary(3'd5, 16'h0000);
        chk_st("R9 write", 16'h0000, 16'h0200);
        irq_n = 1'b0; nmi_n = 1'b0; disp_rdy = 1'b1; ret_pc = 16'h0300;
        mid();
        chk_rd("R2 R5 nmi wins", 1'b1, 16'h0002);
        commit();
        chk_st("R5 nmi entry", 16'h0002, 16'h0300);
        irq_n = 1'b0; nmi_n = 1'b0; disp_rdy = 1'b1;
        mid();
        chk_rd("R5 irq masked after", 1'b0, 16'h0);
        commit();
        mid(); commit();
    endtask

    task automatic t_nmi_pending();
        nmi_n = 1'b0; disp_rdy = 1'b0;
        mid();
        chk_rd("R3 not ready", 1'b0, 16'h0);
        commit();
        mid(); commit();
        disp_rdy = 1'b1; ret_pc = 16'h0400;
        mid();
        chk_rd("R3 pending taken", 1'b1, 16'h0002);
        commit();
        chk(epc === 16'h0400, "R3 epc", epc, 16'h0400);
        disp_rdy = 1'b1;
        mid();
        chk_rd("R3 once", 1'b0, 16'h0);
        commit();
    endtask

    task automatic t_swi();
        boundary(3'd5, 16'h0001);
        disp_rdy = 1'b1; cmd = 3'd3; swi_vec = 2'd1; ret_pc = 16'h1234;
        mid();
        chk_rd("R7 swi 1", 1'b1, 16'h0004);
        commit();
        chk_st("R7 swi 1", 16'h0007, 16'h1234);
        disp_rdy = 1'b1; cmd = 3'd3; swi_vec = 2'd3; ret_pc = 16'h5555;
        mid();
        chk_rd("R7 swi nop", 1'b0, 16'h0);
        commit();
        chk_st("R7 swi nop", 16'h0007, 16'h1234);
        disp_rdy = 1'b1; cmd = 3'd3; swi_vec = 2'd2; ret_pc = 16'h2222;
        mid();
        chk_rd("R7 swi 2", 1'b1, 16'h0006);
        commit();
        chk_st("R7 swi 2", 16'h000F, 16'h2222);
    endtask

    task automatic t_return();
        boundary(3'd5, 16'h0006);
        chk_st("R9 write", 16'h0006, 16'h2222);
        disp_rdy = 1'b1; cmd = 3'd4;
        mid();
        chk_rd("R8 return", 1'b1, 16'h2222);
        commit();
        chk_st("R8 restore", 16'h0005, 16'h2222);
        boundary(3'd1, 16'd0);
        irq_n = 1'b0; disp_rdy = 1'b1; cmd = 3'd4; ret_pc = 16'h0900;
        mid();
        chk_rd("R10 return fires irq", 1'b1, 16'h0006);
        commit();
        chk_st("R6 return then irq", 16'h0007, 16'h2222);
    endtask

    initial begin
        #(200000 * 8);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_clear_fires_irq();
        t_set_blocks_irq();
        t_masked_wake();
        t_irq_entry();
        t_ignored();
        t_nmi_over_irq();
        t_nmi_pending();
        t_swi();
        t_return();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule